// File: doc/BRIEF.md
# Runtime-Selectable QAM Symbol Mapper

This block turns a serial stream of coded bits into complex constellation points for an OFDM transmit chain. Bits arrive one per beat on an AXI4-Stream sink; each completed bit group leaves as one beat on an AXI4-Stream source carrying a signed 16-bit in-phase sample and a signed 16-bit quadrature sample. The group size and the constellation follow a modulation scheme that software may change at any time: QPSK, 16-QAM or 64-QAM.

Software writes the scheme through a small AXI4-Lite register slave. A new scheme never mixes with the old one inside a symbol. When a switch is applied, any bits already collected for the old scheme are thrown away and their number is added to a counter that software can read. A value outside the three legal codes is rejected and sets a sticky error flag. Back-pressure from the output stalls the input, so no bit and no symbol is ever lost. A frame end marked on the input travels to the symbol that uses the marked bit.

Top module: `qam_symbol_mapper`

## Requirements
- R1: After reset the output holds no symbol (mAxisValid low), the input is ready, the scheme register at offset 0x0 reads 0 (QPSK) and the status register at offset 0x4 reads 0.
- R2: Under QPSK (code 0) each symbol uses 2 bits; the first bit received sets I and the second sets Q; bit 0 maps to -11585 and bit 1 to +11585.
- R3: Under 16-QAM (code 1) each symbol uses 4 bits; the first two (first received is the MSB) set I and the last two set Q; per axis 00, 01, 11, 10 map to -3, -1, +1, +3 times 5181.
- R4: Under 64-QAM (code 2) each symbol uses 6 bits; the first three set I and the last three set Q, MSB first; per axis 000, 001, 011, 010, 110, 111, 101, 100 map to -7, -5, -3, -1, +1, +3, +5, +7 times 2528.
- R5: While mAxisValid is high and mAxisReady low, the output beat (I, Q, last) holds unchanged and sAxisReady is low; no symbol is dropped or repeated once the stall ends.
- R6: A write of 0, 1 or 2 to offset 0x0 is applied one cycle after the write is accepted, with sAxisReady low during that cycle; every bit accepted afterwards is grouped and mapped under the new scheme, and offset 0x0 then reads the new code.
- R7: When a scheme write is applied, bits of an incomplete group are discarded and never appear in any output symbol; their number is added to the drop counter in bits [15:0] of offset 0x4.
- R8: A write of any value above 2 to offset 0x0 leaves the scheme unchanged and sets bit 16 of offset 0x4, which stays set until reset.
- R9: The symbol that consumes a bit marked with sAxisLast carries mAxisLast high; if the marked bit ends an incomplete group, the group is completed with zero bits and emitted at once. Every other symbol carries mAxisLast low.
- R10: Every register write is answered with an OKAY (0) write response and every read with an OKAY read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sAxisValid | input | 1 | Input bit valid |
| sAxisReady | output | 1 | Input bit accepted when high with valid |
| sAxisData | input | 1 | Coded bit |
| sAxisLast | input | 1 | Marks the last bit of a frame |
| mAxisValid | output | 1 | Output symbol valid |
| mAxisReady | input | 1 | Downstream accepts the symbol |
| mAxisI | output | 16 | In-phase sample, two's complement |
| mAxisQ | output | 16 | Quadrature sample, two's complement |
| mAxisLast | output | 1 | Symbol carries the frame end |
| regAwAddr | input | 4 | Write address |
| regAwValid | input | 1 | Write address valid |
| regAwReady | output | 1 | Write address accepted |
| regWData | input | 32 | Write data |
| regWValid | input | 1 | Write data valid |
| regWReady | output | 1 | Write data accepted |
| regBResp | output | 2 | Write response code |
| regBValid | output | 1 | Write response valid |
| regBReady | input | 1 | Write response taken |
| regArAddr | input | 4 | Read address |
| regArValid | input | 1 | Read address valid |
| regArReady | output | 1 | Read address accepted |
| regRData | output | 32 | Read data |
| regRResp | output | 2 | Read response code |
| regRValid | output | 1 | Read data valid |
| regRReady | input | 1 | Read data taken |

## Verification
The assertions take for granted that the scheme only ever changes through the write channel and that reset is held at the start, so the partial-group count and the drop counter begin from zero; they place no limit on how the downstream ready toggles. The stimulus keeps within the register handshake by issuing one request at a time with both response readies held high, so a write is never offered while its predecessor's response is outstanding. Stream inputs change only on falling edges, and the stall scenario holds a bit on the input while the output is blocked, which is the case the hold and stall properties guard.

// File: rtl/qam_map_pkg.sv
package qam_map_pkg;

  // Scheme codes as written by software to the scheme register.
  typedef enum logic [1:0] {
    SCH_QPSK  = 2'd0,
    SCH_QAM16 = 2'd1,
    SCH_QAM64 = 2'd2
  } scheme_e;

  // Largest bit group (64-QAM) and the width of a group counter.
  localparam int MAX_BITS = 6;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);
  localparam int AXIS_W   = MAX_BITS / 2;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    flush;   // apply a pending scheme: drop the partial group
    scheme_e scheme;  // scheme in force for grouping and mapping
  } mapCtl_t;

endpackage

// File: rtl/qam_map_axis.sv
module qam_map_axis
  import qam_map_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int SCALE_QPSK  = 11585,
  parameter int SCALE_QAM16 = 5181,
  parameter int SCALE_QAM64 = 2528
) (
  input  scheme_e                     scheme,
  input  logic [AXIS_W-1:0]           bits,
  output logic signed [SAMPLE_W-1:0]  sample
);

  logic [AXIS_W-1:0] rank;
  int span;
  int scale;
  int level;

  // Gray code to rank, then rank to an odd level centred on zero.
  always_comb begin
    case (scheme)
      SCH_QPSK: begin
        rank  = {2'b00, bits[0]};
        span  = 1;
        scale = SCALE_QPSK;
      end
      SCH_QAM16: begin
        rank  = {1'b0, bits[1], bits[1] ^ bits[0]};
        span  = 3;
        scale = SCALE_QAM16;
      end
      default: begin
        rank  = {bits[2], bits[2] ^ bits[1], bits[2] ^ bits[1] ^ bits[0]};
        span  = 7;
        scale = SCALE_QAM64;
      end
    endcase
    level  = 2 * int'(rank) - span;
    sample = SAMPLE_W'(level * scale);
  end

endmodule

// File: rtl/qam_map_datapath.sv
module qam_map_datapath
  import qam_map_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int SCALE_QPSK  = 11585,
  parameter int SCALE_QAM16 = 5181,
  parameter int SCALE_QAM64 = 2528
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  mapCtl_t                    ctl,
  input  logic                       sValid,
  output logic                       sReady,
  input  logic                       sData,
  input  logic                       sLast,
  output logic                       mValid,
  input  logic                       mReady,
  output logic signed [SAMPLE_W-1:0] mI,
  output logic signed [SAMPLE_W-1:0] mQ,
  output logic                       mLast,
  output logic [CNT_W-1:0]           partialCnt
);

  logic [MAX_BITS-2:0] bitBuf;
  logic [CNT_W-1:0]    bitCnt;
  logic [CNT_W-1:0]    need;
  logic [CNT_W-1:0]    newCnt;
  logic [CNT_W-1:0]    padShift;
  logic [MAX_BITS-1:0] newBuf;
  logic [MAX_BITS-1:0] padded;
  logic [AXIS_W-1:0]   axisBits   [2];
  logic signed [SAMPLE_W-1:0] axisSample [2];
  logic outStall;
  logic take;
  logic finish;
  logic mValidQ;
  logic mLastQ;
  logic signed [SAMPLE_W-1:0] mIQ;
  logic signed [SAMPLE_W-1:0] mQQ;

  always_comb begin
    case (ctl.scheme)
      SCH_QPSK:  need = CNT_W'(2);
      SCH_QAM16: need = CNT_W'(4);
      default:   need = CNT_W'(MAX_BITS);
    endcase
    outStall = mValidQ && !mReady;
    sReady   = !outStall && !ctl.flush;
    take     = sValid && sReady;
    newBuf   = {bitBuf, sData};
    newCnt   = bitCnt + CNT_W'(1);
    finish   = take && ((newCnt == need) || sLast);
    padShift = need - newCnt;
    padded   = newBuf << padShift;
  end

  // Split a left-aligned group into its I half and Q half.
  always_comb begin
    case (ctl.scheme)
      SCH_QPSK: begin
        axisBits[0] = {2'b00, padded[1]};
        axisBits[1] = {2'b00, padded[0]};
      end
      SCH_QAM16: begin
        axisBits[0] = {1'b0, padded[3:2]};
        axisBits[1] = {1'b0, padded[1:0]};
      end
      default: begin
        axisBits[0] = padded[5:3];
        axisBits[1] = padded[2:0];
      end
    endcase
  end

  for (genvar ax = 0; ax < 2; ax++) begin : g_axis
    qam_map_axis #(
      .SAMPLE_W   (SAMPLE_W),
      .SCALE_QPSK (SCALE_QPSK),
      .SCALE_QAM16(SCALE_QAM16),
      .SCALE_QAM64(SCALE_QAM64)
    ) u_axis (
      .scheme(ctl.scheme),
      .bits  (axisBits[ax]),
      .sample(axisSample[ax])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitBuf  <= '0;
      bitCnt  <= '0;
      mValidQ <= 1'b0;
      mIQ     <= '0;
      mQQ     <= '0;
      mLastQ  <= 1'b0;
    end else begin
      if (ctl.flush || finish) begin
        bitBuf <= '0;
        bitCnt <= '0;
      end else if (take) begin
        bitBuf <= newBuf[MAX_BITS-2:0];
        bitCnt <= newCnt;
      end
      if (finish) begin
        mValidQ <= 1'b1;
        mIQ     <= axisSample[0];
        mQQ     <= axisSample[1];
        mLastQ  <= sLast;
      end else if (mValidQ && mReady) begin
        mValidQ <= 1'b0;
      end
    end
  end

  assign mValid     = mValidQ;
  assign mI         = mIQ;
  assign mQ         = mQQ;
  assign mLast      = mLastQ;
  assign partialCnt = bitCnt;

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mValidQ && !mReady) |=> (mValidQ && $stable(mIQ) && $stable(mQQ) && $stable(mLastQ)));

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> (bitCnt == '0));

  // R6
  group_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < need);

  // R2
  nonzero_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    mValidQ |-> ((mIQ != '0) && (mQQ != '0)));

endmodule

// File: rtl/qam_map_ctrl.sv
module qam_map_ctrl
  import qam_map_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              awValid,
  output logic              awReady,
  input  logic [DATA_W-1:0] wData,
  input  logic              wValid,
  output logic              wReady,
  output logic [1:0]        bResp,
  output logic              bValid,
  input  logic              bReady,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic              arValid,
  output logic              arReady,
  output logic [DATA_W-1:0] rData,
  output logic [1:0]        rResp,
  output logic              rValid,
  input  logic              rReady,
  input  logic [CNT_W-1:0]  partialCnt,
  output mapCtl_t           ctl
);

  localparam logic [ADDR_W-1:0] SCHEME_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(4);
  localparam int STAT_PAD_W = DATA_W - DROP_W - 1;
  localparam int SCH_PAD_W  = DATA_W - 2;

  scheme_e             activeScheme;
  scheme_e             pendScheme;
  logic                pendValid;
  logic                errFlag;
  logic [DROP_W-1:0]   dropCnt;
  logic                bValidQ;
  logic                rValidQ;
  logic [DATA_W-1:0]   rDataQ;
  logic [DATA_W-1:0]   readMux;
  logic                wrFire;
  logic                schemeWrite;
  logic                badValue;
  logic                rdFire;

  always_comb begin
    wrFire      = awValid && wValid && !bValidQ;
    schemeWrite = wrFire && (awAddr == SCHEME_ADDR);
    badValue    = wData > DATA_W'(2);
    rdFire      = arValid && !rValidQ;
    if (arAddr == SCHEME_ADDR)
      readMux = {{SCH_PAD_W{1'b0}}, activeScheme};
    else if (arAddr == STATUS_ADDR)
      readMux = {{STAT_PAD_W{1'b0}}, errFlag, dropCnt};
    else
      readMux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeScheme <= SCH_QPSK;
      pendScheme   <= SCH_QPSK;
      pendValid    <= 1'b0;
      errFlag      <= 1'b0;
      dropCnt      <= '0;
      bValidQ      <= 1'b0;
      rValidQ      <= 1'b0;
      rDataQ       <= '0;
    end else begin
      if (pendValid) begin
        activeScheme <= pendScheme;
        dropCnt      <= dropCnt + DROP_W'(partialCnt);
        pendValid    <= 1'b0;
      end
      if (schemeWrite) begin
        if (badValue) begin
          errFlag <= 1'b1;
        end else begin
          pendValid  <= 1'b1;
          pendScheme <= scheme_e'(wData[1:0]);
        end
      end
      if (wrFire) bValidQ <= 1'b1;
      else if (bValidQ && bReady) bValidQ <= 1'b0;
      if (rdFire) begin
        rValidQ <= 1'b1;
        rDataQ  <= readMux;
      end else if (rValidQ && rReady) begin
        rValidQ <= 1'b0;
      end
    end
  end

  assign awReady    = wrFire;
  assign wReady     = wrFire;
  assign bValid     = bValidQ;
  assign bResp      = 2'b00;
  assign arReady    = !rValidQ;
  assign rValid     = rValidQ;
  assign rData      = rDataQ;
  assign rResp      = 2'b00;
  assign ctl.flush  = pendValid;
  assign ctl.scheme = activeScheme;

  // R8
  bad_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (schemeWrite && badValue) |=> (errFlag && !pendValid && $stable(activeScheme)));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R7
  drop_only_on_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendValid |=> $stable(dropCnt));

  // R6
  scheme_only_on_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendValid |=> $stable(activeScheme));

endmodule

// File: rtl/qam_symbol_mapper.sv
module qam_symbol_mapper
  import qam_map_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int DROP_W      = 16,
  parameter int SAMPLE_W    = 16,
  parameter int SCALE_QPSK  = 11585,
  parameter int SCALE_QAM16 = 5181,
  parameter int SCALE_QAM64 = 2528
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sAxisValid,
  output logic                       sAxisReady,
  input  logic                       sAxisData,
  input  logic                       sAxisLast,
  output logic                       mAxisValid,
  input  logic                       mAxisReady,
  output logic signed [SAMPLE_W-1:0] mAxisI,
  output logic signed [SAMPLE_W-1:0] mAxisQ,
  output logic                       mAxisLast,
  input  logic [ADDR_W-1:0]          regAwAddr,
  input  logic                       regAwValid,
  output logic                       regAwReady,
  input  logic [DATA_W-1:0]          regWData,
  input  logic                       regWValid,
  output logic                       regWReady,
  output logic [1:0]                 regBResp,
  output logic                       regBValid,
  input  logic                       regBReady,
  input  logic [ADDR_W-1:0]          regArAddr,
  input  logic                       regArValid,
  output logic                       regArReady,
  output logic [DATA_W-1:0]          regRData,
  output logic [1:0]                 regRResp,
  output logic                       regRValid,
  input  logic                       regRReady
);

  mapCtl_t          ctl;
  logic [CNT_W-1:0] partialCnt;

  qam_map_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DROP_W(DROP_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .awAddr    (regAwAddr),
    .awValid   (regAwValid),
    .awReady   (regAwReady),
    .wData     (regWData),
    .wValid    (regWValid),
    .wReady    (regWReady),
    .bResp     (regBResp),
    .bValid    (regBValid),
    .bReady    (regBReady),
    .arAddr    (regArAddr),
    .arValid   (regArValid),
    .arReady   (regArReady),
    .rData     (regRData),
    .rResp     (regRResp),
    .rValid    (regRValid),
    .rReady    (regRReady),
    .partialCnt(partialCnt),
    .ctl       (ctl)
  );

  qam_map_datapath #(
    .SAMPLE_W   (SAMPLE_W),
    .SCALE_QPSK (SCALE_QPSK),
    .SCALE_QAM16(SCALE_QAM16),
    .SCALE_QAM64(SCALE_QAM64)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sValid    (sAxisValid),
    .sReady    (sAxisReady),
    .sData     (sAxisData),
    .sLast     (sAxisLast),
    .mValid    (mAxisValid),
    .mReady    (mAxisReady),
    .mI        (mAxisI),
    .mQ        (mAxisQ),
    .mLast     (mAxisLast),
    .partialCnt(partialCnt)
  );

endmodule

// File: tb/qam_symbol_mapper_bench.sv
module qam_symbol_mapper_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q_STEP     = CLK_PERIOD / 4;

  logic clk = 1'b0;
  logic rstN;
  logic sValid, sReady, sData, sLast;
  logic mValid, mReady, mLast;
  logic signed [15:0] mI, mQ;
  logic [3:0]  awAddr, arAddr;
  logic        awValid, awReady, wValid, wReady, bValid, bReady;
  logic        arValid, arReady, rValid, rReady;
  logic [31:0] wData, rData;
  logic [1:0]  bResp, rResp;

  int vecs = 0;
  int errs = 0;
  int capI [0:511];
  int capQ [0:511];
  int capL [0:511];
  int capN = 0;
  int dropExp = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  qam_symbol_mapper u_qam_symbol_mapper (
    .clk(clk), .rstN(rstN),
    .sAxisValid(sValid), .sAxisReady(sReady), .sAxisData(sData), .sAxisLast(sLast),
    .mAxisValid(mValid), .mAxisReady(mReady), .mAxisI(mI), .mAxisQ(mQ), .mAxisLast(mLast),
    .regAwAddr(awAddr), .regAwValid(awValid), .regAwReady(awReady),
    .regWData(wData), .regWValid(wValid), .regWReady(wReady),
    .regBResp(bResp), .regBValid(bValid), .regBReady(bReady),
    .regArAddr(arAddr), .regArValid(arValid), .regArReady(arReady),
    .regRData(rData), .regRResp(rResp), .regRValid(rValid), .regRReady(rReady)
  );

  // Output monitor: a beat seen here completes at the next rising edge.
  always begin
    @(negedge clk);
    #(Q_STEP);
    if (rstN === 1'b1 && mValid && mReady) begin
      capI[capN] = int'(mI);
      capQ[capN] = int'(mQ);
      capL[capN] = int'(mLast);
      capN++;
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Per-axis levels stated in R2, R3 and R4.
  function automatic int expAxis(input int sch, input int b);
    int lv;
    lv = 0;
    if (sch == 0) begin
      lv = (b == 1) ? 1 : -1;
      return lv * 11585;
    end else if (sch == 1) begin
      case (b)
        0: lv = -3;
        1: lv = -1;
        3: lv = 1;
        default: lv = 3;
      endcase
      return lv * 5181;
    end
    case (b)
      0: lv = -7;
      1: lv = -5;
      3: lv = -3;
      2: lv = -1;
      6: lv = 1;
      7: lv = 3;
      5: lv = 5;
      default: lv = 7;
    endcase
    return lv * 2528;
  endfunction

  task automatic checkSym(input string tag, input int idx, input int sch,
                          input int iB, input int qB, input int lastExp);
    checkEq({tag, " I"}, capI[idx], expAxis(sch, iB));
    checkEq({tag, " Q"}, capQ[idx], expAxis(sch, qB));
    checkEq({tag, " last"}, capL[idx], lastExp);
  endtask

  task automatic sendBit(input logic b, input logic last);
    bit done;
    done = 1'b0;
    @(negedge clk);
    sValid = 1'b1;
    sData  = b;
    sLast  = last;
    while (!done) begin
      #(Q_STEP);
      if (sReady) done = 1'b1;
      @(posedge clk);
      if (!done) @(negedge clk);
    end
    @(negedge clk);
    sValid = 1'b0;
    sLast  = 1'b0;
  endtask

  // Sends nbits of value, most significant first; last marks the final bit.
  task automatic sendGroup(input int nbits, input int value, input logic last);
    for (int k = nbits - 1; k >= 0; k--) begin
      sendBit(logic'((value >> k) & 1), (k == 0) ? last : 1'b0);
    end
  endtask

  task automatic regWrite(input logic [3:0] addr, input logic [31:0] data);
    bit done;
    done = 1'b0;
    @(negedge clk);
    awAddr = addr; awValid = 1'b1;
    wData  = data; wValid  = 1'b1;
    while (!done) begin
      #(Q_STEP);
      if (awReady) done = 1'b1;
      @(posedge clk);
      if (!done) @(negedge clk);
    end
    @(negedge clk);
    awValid = 1'b0;
    wValid  = 1'b0;
    done = 1'b0;
    while (!done) begin
      #(Q_STEP);
      if (bValid) begin
        done = 1'b1;
        // R10
        checkEq("R10 write response", int'(bResp), 0);
      end
      @(posedge clk);
      if (!done) @(negedge clk);
    end
  endtask

  task automatic regRead(input logic [3:0] addr, output int data);
    bit done;
    done = 1'b0;
    data = 0;
    @(negedge clk);
    arAddr = addr; arValid = 1'b1;
    while (!done) begin
      #(Q_STEP);
      if (arReady) done = 1'b1;
      @(posedge clk);
      if (!done) @(negedge clk);
    end
    @(negedge clk);
    arValid = 1'b0;
    done = 1'b0;
    while (!done) begin
      #(Q_STEP);
      if (rValid) begin
        done = 1'b1;
        data = int'(rData);
        // R10
        checkEq("R10 read response", int'(rResp), 0);
      end
      @(posedge clk);
      if (!done) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    int v;
    @(negedge clk);
    #(Q_STEP);
    checkEq("R1 no symbol after reset", int'(mValid), 0);
    checkEq("R1 input ready after reset", int'(sReady), 1);
    regRead(4'h0, v);
    checkEq("R1 scheme reads QPSK", v, 0);
    regRead(4'h4, v);
    checkEq("R1 status clear", v, 0);
  endtask

  task automatic testQpsk();
    int start;
    start = capN;
    sendGroup(2, 2'b00, 1'b0);
    sendGroup(2, 2'b10, 1'b0);
    sendGroup(2, 2'b01, 1'b0);
    sendGroup(2, 2'b11, 1'b0);
    idle(3);
    checkEq("R2 qpsk symbol count", capN - start, 4);
    checkSym("R2 qpsk 00", start,     0, 0, 0, 0);
    checkSym("R2 qpsk 10", start + 1, 0, 1, 0, 0);
    checkSym("R2 qpsk 01", start + 2, 0, 0, 1, 0);
    checkSym("R2 qpsk 11", start + 3, 0, 1, 1, 0);
  endtask

  task automatic testQam16();
    int start, v;
    regWrite(4'h0, 32'd1);
    regRead(4'h0, v);
    checkEq("R6 scheme reads 16-QAM", v, 1);
    start = capN;
    sendGroup(4, 4'b0010, 1'b0);
    sendGroup(4, 4'b1101, 1'b0);
    sendGroup(4, 4'b1011, 1'b0);
    idle(3);
    checkEq("R3 qam16 symbol count", capN - start, 3);
    checkSym("R3 qam16 0010", start,     1, 0, 2, 0);
    checkSym("R3 qam16 1101", start + 1, 1, 3, 1, 0);
    checkSym("R3 qam16 1011", start + 2, 1, 2, 3, 0);
  endtask

  task automatic testQam64();
    int start, v;
    regWrite(4'h0, 32'd2);
    regRead(4'h0, v);
    checkEq("R6 scheme reads 64-QAM", v, 2);
    start = capN;
    sendGroup(6, 6'b100011, 1'b0);
    sendGroup(6, 6'b010111, 1'b0);
    sendGroup(6, 6'b000101, 1'b0);
    sendGroup(6, 6'b110001, 1'b0);
    idle(3);
    checkEq("R4 qam64 symbol count", capN - start, 4);
    checkSym("R4 qam64 100011", start,     2, 4, 3, 0);
    checkSym("R4 qam64 010111", start + 1, 2, 2, 7, 0);
    checkSym("R4 qam64 000101", start + 2, 2, 0, 5, 0);
    checkSym("R4 qam64 110001", start + 3, 2, 6, 1, 0);
  endtask

  task automatic testBackpressure();
    int start;
    regWrite(4'h0, 32'd0);
    @(negedge clk);
    mReady = 1'b0;
    start = capN;
    sendGroup(2, 2'b11, 1'b0);
    @(negedge clk);
    sValid = 1'b1; sData = 1'b0; sLast = 1'b0;
    for (int c = 0; c < 4; c++) begin
      #(Q_STEP);
      checkEq("R5 input stalled", int'(sReady), 0);
      checkEq("R5 symbol held", int'(mValid), 1);
      checkEq("R5 I held", int'(mI), 11585);
      @(negedge clk);
    end
    mReady = 1'b1;
    #(Q_STEP);
    checkEq("R5 input resumes", int'(sReady), 1);
    @(posedge clk);
    @(negedge clk);
    sValid = 1'b0;
    sendBit(1'b1, 1'b0);
    idle(3);
    checkEq("R5 symbol count after stall", capN - start, 2);
    checkSym("R5 held symbol", start,     0, 1, 1, 0);
    checkSym("R5 next symbol", start + 1, 0, 0, 1, 0);
  endtask

  task automatic testSwitchFlush();
    int start, v;
    regWrite(4'h0, 32'd2);
    start = capN;
    sendGroup(3, 3'b101, 1'b0);
    regWrite(4'h0, 32'd1);
    dropExp += 3;
    regRead(4'h4, v);
    checkEq("R7 dropped bits counted", v & 32'hFFFF, dropExp);
    checkEq("R7 no error on legal write", (v >> 16) & 1, 0);
    sendGroup(4, 4'b0111, 1'b0);
    idle(3);
    checkEq("R7 partial bits not emitted", capN - start, 1);
    checkSym("R6 new scheme after switch", start, 1, 1, 3, 0);
    regWrite(4'h0, 32'd1);
    regRead(4'h4, v);
    checkEq("R7 clean switch drops nothing", v & 32'hFFFF, dropExp);
  endtask

  task automatic testBadWrite();
    int start, v;
    regWrite(4'h0, 32'd3);
    regRead(4'h0, v);
    checkEq("R8 scheme unchanged after 3", v, 1);
    regRead(4'h4, v);
    checkEq("R8 error flag set", (v >> 16) & 1, 1);
    regWrite(4'h0, 32'd9);
    regRead(4'h0, v);
    checkEq("R8 scheme unchanged after 9", v, 1);
    regWrite(4'h0, 32'd1);
    regRead(4'h4, v);
    checkEq("R8 error flag sticky", (v >> 16) & 1, 1);
    start = capN;
    sendGroup(4, 4'b1000, 1'b0);
    idle(3);
    checkEq("R8 stream unaffected count", capN - start, 1);
    checkSym("R8 stream still 16-QAM", start, 1, 2, 0, 0);
  endtask

  task automatic testLast();
    int start;
    start = capN;
    sendGroup(4, 4'b0110, 1'b1);
    sendGroup(2, 2'b11, 1'b1);
    idle(3);
    checkEq("R9 last symbols count", capN - start, 2);
    checkSym("R9 full group with last", start,     1, 1, 2, 1);
    checkSym("R9 padded group with last", start + 1, 1, 3, 0, 1);
    regWrite(4'h0, 32'd2);
    start = capN;
    sendBit(1'b1, 1'b1);
    idle(3);
    checkEq("R9 single bit frame count", capN - start, 1);
    checkSym("R9 single bit padded", start, 2, 4, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errs++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    sValid = 1'b0; sData = 1'b0; sLast = 1'b0;
    mReady = 1'b1;
    awAddr = '0; awValid = 1'b0; wData = '0; wValid = 1'b0; bReady = 1'b1;
    arAddr = '0; arValid = 1'b0; rReady = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testQpsk();
    testQam16();
    testQam64();
    testBackpressure();
    testSwitchFlush();
    testBadWrite();
    testLast();
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule